// File: doc/BRIEF.md
# Outstanding Request Tag Tracker

This block sits between an engine that issues requests and the packet link that carries them. Every accepted request gets a free source tag, and the block writes that tag into the outgoing header together with the local node identifier and unit identifier. While the request is outstanding, the block keeps the requester's context: command, address and requester id.

A response carries only a tag. The block finds the matching entry, returns its stored context on the completion port and frees the tag. Responses may arrive in any order. If a response carries a tag that is not in use, the block flags an error and drops the response. The request path is a combinational pass-through with no buffering. It stalls only when every tag is in use or the link is not ready.

Top module: `req_tag_tracker`

## Requirements
- R1: After reset, `outstanding_o` is 0 and `cpl_valid_o` and `rsp_err_o` are low. `req_ready_o` follows `out_ready_i` because every tag is free.
- R2: An accepted request appears on the output port in the same cycle. Command and address pass through unchanged, `out_node_o` equals `node_id_i` and `out_unit_o` equals `unit_id_i`.
- R3: The tag placed in the header is the lowest-numbered free tag in 0..NUM_TAGS-1. With the default of 32 tags it is a 5-bit value.
- R4: While all tags are in use, `req_ready_o` and `out_valid_o` stay low.
- R5: A response whose tag is in use causes a one-cycle `cpl_valid_o` pulse in the next cycle. The pulse carries the tag and the command, address and requester id stored for it, and the tag becomes free.
- R6: A response whose tag is not in use causes a one-cycle `rsp_err_o` pulse in the next cycle. It produces no completion and changes neither the count nor the order of allocation. A tag allocated in the same cycle counts as not yet in use.
- R7: A tag released by a response can be allocated from the following cycle onward, not in the cycle of the response.
- R8: `outstanding_o` equals accepted requests minus retired responses and is updated at the clock edge.
- R9: Responses may retire tags in any order, and each completion returns the context of its own tag.
- R10: An allocation and a retirement in the same cycle both take effect, and the count is then unchanged.
- R11: While `out_ready_i` is low, `req_ready_o` is low and no tag is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | NODE_W | Local node identifier stamped into headers |
| unit_id_i | input | UNIT_W | Local unit identifier stamped into headers |
| req_valid_i | input | 1 | Request offered by the engine |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_cmd_i | input | CMD_W | Request command |
| req_addr_i | input | ADDR_W | Request address |
| req_rid_i | input | RID_W | Requester id |
| out_valid_o | output | 1 | Stamped request offered to the link |
| out_ready_i | input | 1 | Link can take a request |
| out_cmd_o | output | CMD_W | Forwarded command |
| out_addr_o | output | ADDR_W | Forwarded address |
| out_node_o | output | NODE_W | Stamped node identifier |
| out_unit_o | output | UNIT_W | Stamped unit identifier |
| out_tag_o | output | TAG_W | Stamped source tag |
| rsp_valid_i | input | 1 | Response arrives |
| rsp_tag_i | input | TAG_W | Tag carried by the response |
| cpl_valid_o | output | 1 | Completion pulse |
| cpl_tag_o | output | TAG_W | Retired tag |
| cpl_cmd_o | output | CMD_W | Stored command |
| cpl_addr_o | output | ADDR_W | Stored address |
| cpl_rid_o | output | RID_W | Stored requester id |
| rsp_err_o | output | 1 | Response carried a tag that is not in use |
| outstanding_o | output | CNT_W | Number of tags in use |

## Verification
The functions that can coincide are allocation of a new tag and retirement of another tag by a response. Both touch the busy set and the count in the same cycle. The bench provokes this by offering a request in the cycle a response for tag 0 arrives. It expects the request to receive the next free tag rather than tag 0, the count to stay the same, and tag 0 to be handed out in the following cycle. It also fills all 32 tags and sends a response while a request is still waiting, which checks that the waiting request gets the released tag only one cycle later.

// File: rtl/tag_trk_pkg.sv
package tag_trk_pkg;
  typedef enum logic [1:0] {
    RET_NONE = 2'd0,
    RET_HIT  = 2'd1,
    RET_MISS = 2'd2
  } ret_kind_e;
endpackage

// File: rtl/tag_pick.sv
module tag_pick #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 5
) (
  input  logic [N-1:0] busy_i,
  output logic [W-1:0] tag_o,
  output logic         any_o
);
  always_comb begin
    any_o = 1'b0;
    tag_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        any_o = 1'b1;
        tag_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/tag_ledger.sv
module tag_ledger #(
  parameter int unsigned N     = 32,
  parameter int unsigned W     = 5,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [W-1:0]     alloc_tag_i,
  input  logic             rel_i,
  input  logic [W-1:0]     rel_tag_i,
  output logic [N-1:0]     busy_o,
  output logic [CNT_W-1:0] count_o
);
  logic [N-1:0] busy_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_q[g] <= 1'b0;
      else if (alloc_i && alloc_tag_i == W'(g)) busy_q[g] <= 1'b1;
      else if (rel_i && rel_tag_i == W'(g)) busy_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else count_o <= count_o + CNT_W'(alloc_i) - CNT_W'(rel_i);
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 50
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/req_tag_tracker.sv
module req_tag_tracker
  import tag_trk_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 32,
  parameter int unsigned CMD_W    = 6,
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned RID_W    = 4,
  parameter int unsigned NODE_W   = 3,
  parameter int unsigned UNIT_W   = 2,
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS),
  localparam int unsigned CNT_W   = $clog2(NUM_TAGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NODE_W-1:0] node_id_i,
  input  logic [UNIT_W-1:0] unit_id_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [RID_W-1:0]  req_rid_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CMD_W-1:0]  out_cmd_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [NODE_W-1:0] out_node_o,
  output logic [UNIT_W-1:0] out_unit_o,
  output logic [TAG_W-1:0]  out_tag_o,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  output logic              cpl_valid_o,
  output logic [TAG_W-1:0]  cpl_tag_o,
  output logic [CMD_W-1:0]  cpl_cmd_o,
  output logic [ADDR_W-1:0] cpl_addr_o,
  output logic [RID_W-1:0]  cpl_rid_o,
  output logic              rsp_err_o,
  output logic [CNT_W-1:0]  outstanding_o
);
  localparam int unsigned CTX_W = CMD_W + ADDR_W + RID_W;

  logic [NUM_TAGS-1:0] busy;
  logic [TAG_W-1:0]    free_tag;
  logic                any_free, alloc, hit, miss;
  logic [CTX_W-1:0]    ctx_rd;
  ret_kind_e           ret_q;
  logic [TAG_W-1:0]    ret_tag_q;
  logic [CTX_W-1:0]    ret_ctx_q;

  tag_pick #(.N(NUM_TAGS), .W(TAG_W)) u_pick (
    .busy_i(busy), .tag_o(free_tag), .any_o(any_free)
  );

  assign req_ready_o = out_ready_i & any_free;
  assign out_valid_o = req_valid_i & any_free;
  assign alloc       = req_valid_i & req_ready_o;
  assign out_cmd_o   = req_cmd_i;
  assign out_addr_o  = req_addr_i;
  assign out_node_o  = node_id_i;
  assign out_unit_o  = unit_id_i;
  assign out_tag_o   = free_tag;

  // hit uses registered busy: a tag allocated this cycle is not yet live
  assign hit  = rsp_valid_i &  busy[rsp_tag_i];
  assign miss = rsp_valid_i & ~busy[rsp_tag_i];

  tag_ledger #(.N(NUM_TAGS), .W(TAG_W), .CNT_W(CNT_W)) u_ledger (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .alloc_tag_i(free_tag),
    .rel_i(hit), .rel_tag_i(rsp_tag_i),
    .busy_o(busy), .count_o(outstanding_o)
  );

  ctx_store #(.DEPTH(NUM_TAGS), .AW(TAG_W), .DW(CTX_W)) u_ctx (
    .clk_i,
    .we_i(alloc), .waddr_i(free_tag),
    .wdata_i({req_cmd_i, req_addr_i, req_rid_i}),
    .raddr_i(rsp_tag_i), .rdata_o(ctx_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_q     <= RET_NONE;
      ret_tag_q <= '0;
      ret_ctx_q <= '0;
    end else begin
      ret_q     <= hit ? RET_HIT : (miss ? RET_MISS : RET_NONE);
      ret_tag_q <= rsp_tag_i;
      if (hit) ret_ctx_q <= ctx_rd;
    end
  end

  assign cpl_valid_o = (ret_q == RET_HIT);
  assign rsp_err_o   = (ret_q == RET_MISS);
  assign cpl_tag_o   = ret_tag_q;
  assign {cpl_cmd_o, cpl_addr_o, cpl_rid_o} = ret_ctx_q;
endmodule

// File: rtl/tag_trk_chk.sv
module tag_trk_chk #(
  parameter int unsigned NUM_TAGS = 32,
  parameter int unsigned CNT_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             out_valid_o,
  input logic             rsp_valid_i,
  input logic             cpl_valid_o,
  input logic             rsp_err_o,
  input logic [CNT_W-1:0] outstanding_o
);
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outstanding_o == CNT_W'(NUM_TAGS)) |-> (!req_ready_o && !out_valid_o)); // R4
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_o <= CNT_W'(NUM_TAGS)); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (outstanding_o == $past(outstanding_o)
      + CNT_W'($past(req_valid_i && req_ready_o)) - CNT_W'(cpl_valid_o))); // R10
  AST_CPL_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && cpl_valid_o) |-> $past(rsp_valid_i)); // R5
  AST_ERR_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && rsp_err_o) |-> $past(rsp_valid_i)); // R6
  AST_CPL_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpl_valid_o && rsp_err_o)); // R6
endmodule

bind req_tag_tracker tag_trk_chk #(.NUM_TAGS(NUM_TAGS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .out_valid_o(out_valid_o),
  .rsp_valid_i(rsp_valid_i), .cpl_valid_o(cpl_valid_o),
  .rsp_err_o(rsp_err_o), .outstanding_o(outstanding_o)
);

// File: tb/tb_req_tag_tracker.sv
module tb_req_tag_tracker;
  localparam int NT = 32, CW = 6, AW = 40, RW = 4, NW = 3, UW = 2, TW = 5, KW = 6;

  logic clk = 0, rst_ni = 0;
  logic [NW-1:0] node_id = 3'd5;
  logic [UW-1:0] unit_id = 2'd2;
  logic req_valid = 0, out_ready = 1, rsp_valid = 0;
  logic [CW-1:0] req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [RW-1:0] req_rid = '0;
  logic [TW-1:0] rsp_tag = '0;
  logic req_ready, out_valid, cpl_valid, rsp_err;
  logic [CW-1:0] out_cmd, cpl_cmd;
  logic [AW-1:0] out_addr, cpl_addr;
  logic [NW-1:0] out_node;
  logic [UW-1:0] out_unit;
  logic [TW-1:0] out_tag, cpl_tag;
  logic [RW-1:0] cpl_rid;
  logic [KW-1:0] outstanding;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  req_tag_tracker dut (
    .clk_i(clk), .rst_ni, .node_id_i(node_id), .unit_id_i(unit_id),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .req_rid_i(req_rid), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_cmd_o(out_cmd), .out_addr_o(out_addr),
    .out_node_o(out_node), .out_unit_o(out_unit), .out_tag_o(out_tag),
    .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .cpl_valid_o(cpl_valid),
    .cpl_tag_o(cpl_tag), .cpl_cmd_o(cpl_cmd), .cpl_addr_o(cpl_addr),
    .cpl_rid_o(cpl_rid), .rsp_err_o(rsp_err), .outstanding_o(outstanding)
  );

  function automatic logic [CW-1:0] cmd_of(logic [RW-1:0] r);
    return {2'b10, r};
  endfunction
  function automatic logic [AW-1:0] addr_of(logic [RW-1:0] r);
    return {8'hA5, 28'h0, r};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {rv, rid, sv, stag, etag, ecpl, eerr, erid, ecnt}
  localparam int VW = 28;
  localparam logic [VW-1:0] VEC [10] = '{
    {1'b1, 4'd1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 4'd0, 6'd1},
    {1'b1, 4'd2, 1'b0, 5'd0, 5'd1, 1'b0, 1'b0, 4'd0, 6'd2},
    {1'b1, 4'd3, 1'b0, 5'd0, 5'd2, 1'b0, 1'b0, 4'd0, 6'd3},
    {1'b0, 4'd0, 1'b1, 5'd1, 5'd0, 1'b1, 1'b0, 4'd2, 6'd2},
    {1'b1, 4'd4, 1'b0, 5'd0, 5'd1, 1'b0, 1'b0, 4'd0, 6'd3},
    {1'b0, 4'd0, 1'b1, 5'd7, 5'd0, 1'b0, 1'b1, 4'd0, 6'd3},
    {1'b1, 4'd5, 1'b1, 5'd0, 5'd3, 1'b1, 1'b0, 4'd1, 6'd3},
    {1'b1, 4'd6, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 4'd0, 6'd4},
    {1'b0, 4'd0, 1'b1, 5'd2, 5'd0, 1'b1, 1'b0, 4'd3, 6'd3},
    {1'b0, 4'd0, 1'b1, 5'd3, 5'd0, 1'b1, 1'b0, 4'd5, 6'd2}
  };

  task automatic do_reset();
    @(negedge clk);
    req_valid = 0; rsp_valid = 0; out_ready = 1;
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    chk(outstanding == 0, "R1 count", outstanding, 0);
    chk(!cpl_valid && !rsp_err, "R1 pulses", {cpl_valid, rsp_err}, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);

    // vector walk: R2 R3 R5 R6 R9 R10
    foreach (VEC[i]) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      req_valid = v[27]; req_rid = v[26:23];
      req_cmd = cmd_of(v[26:23]); req_addr = addr_of(v[26:23]);
      rsp_valid = v[22]; rsp_tag = v[21:17];
      #1;
      if (v[27]) begin
        chk(out_valid && out_tag == v[16:12], "R3 tag", out_tag, v[16:12]);
        chk(out_cmd == req_cmd && out_addr == req_addr, "R2 payload", out_addr, req_addr);
        chk(out_node == node_id && out_unit == unit_id, "R2 stamp", {out_node, out_unit}, {node_id, unit_id});
      end
      @(posedge clk); #1;
      chk(cpl_valid == v[11], "R5 cpl_valid", cpl_valid, v[11]);
      if (v[11]) begin
        chk(cpl_rid == v[9:6] && cpl_tag == v[21:17], "R9 cpl rid/tag", {cpl_rid, cpl_tag}, {v[9:6], v[21:17]});
        chk(cpl_cmd == cmd_of(v[9:6]) && cpl_addr == addr_of(v[9:6]), "R5 cpl ctx", cpl_addr, addr_of(v[9:6]));
      end
      chk(rsp_err == v[10], "R6 err", rsp_err, v[10]);
      chk(outstanding == v[5:0], "R8 R10 count", outstanding, v[5:0]);
    end
    @(negedge clk);
    req_valid = 0; rsp_valid = 0;
    @(posedge clk); #1;
    chk(!cpl_valid && !rsp_err, "R5 one-cycle pulse", {cpl_valid, rsp_err}, 0);

    // fill all tags
    do_reset();
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      req_valid = 1; req_rid = RW'(t); req_cmd = cmd_of(RW'(t)); req_addr = addr_of(RW'(t));
      #1;
      chk(out_tag == TW'(t), "R3 fill tag", out_tag, t);
    end
    @(negedge clk); #1;
    chk(outstanding == KW'(NT), "R8 full count", outstanding, NT);
    chk(!req_ready && !out_valid, "R4 full stall", {req_ready, out_valid}, 0);
    rsp_valid = 1; rsp_tag = 5'd17;
    #1;
    chk(!req_ready, "R7 no same-cycle reuse", req_ready, 0);
    @(negedge clk);
    rsp_valid = 0;
    #1;
    chk(cpl_valid && cpl_tag == 5'd17, "R5 cpl tag17", cpl_tag, 17);
    chk(cpl_rid == 4'd1, "R9 rid tag17", cpl_rid, 1);
    chk(req_ready && out_tag == 5'd17, "R7 reuse next cycle", out_tag, 17);
    @(posedge clk); #1;
    chk(outstanding == KW'(NT), "R8 refill count", outstanding, NT);

    // release tag 5, then stall link
    @(negedge clk);
    req_valid = 0; rsp_valid = 1; rsp_tag = 5'd5;
    @(negedge clk);
    rsp_valid = 0; req_valid = 1; out_ready = 0;
    #1;
    chk(!req_ready, "R11 ready low", req_ready, 0);
    @(posedge clk); #1;
    chk(outstanding == KW'(NT - 1), "R11 no alloc", outstanding, NT - 1);
    @(negedge clk);
    out_ready = 1;
    #1;
    chk(req_ready && out_tag == 5'd5, "R11 resume tag", out_tag, 5);
    @(negedge clk);
    req_valid = 0;
    // miss on full set leaves count unchanged
    rsp_valid = 1; rsp_tag = 5'd9;
    @(negedge clk);
    rsp_valid = 0;
    #1;
    chk(cpl_valid && !rsp_err, "R5 hit on tag9", {cpl_valid, rsp_err}, 2);
    @(negedge clk);
    rsp_valid = 1; rsp_tag = 5'd9;
    @(negedge clk);
    rsp_valid = 0;
    #1;
    chk(rsp_err && !cpl_valid, "R6 stale tag9", {rsp_err, cpl_valid}, 2);
    chk(outstanding == KW'(NT - 1), "R6 count kept", outstanding, NT - 1);
    chk(out_tag == 5'd9, "R6 order kept", out_tag, 9);

    finish_run();
  end
endmodule